// File: doc/BRIEF.md
# Boundary-scan test access port

This block is the serial test and identification port of a small device. An external tester clocks it through a scan clock and steers a sixteen-state controller with a mode-select line that is sampled on each rising edge. A five-bit instruction register picks which data register sits between the serial input and the serial output. The choices are a one-bit pass-through stage, a 32-bit identification word, and a boundary register that wraps a few device pins.

Several such ports can be chained, the serial output of one feeding the serial input of the next. For this reason every shift state moves exactly one bit per clock, least-significant bit first. The serial output changes on the falling edge and has a separate enable that is high only while a shift state is active.

In the drive opcode the boundary register's update stage takes over the pins. In the snapshot opcode the pins are captured while the core keeps driving them. An active-low asynchronous reset, or five rising edges in a row with mode-select high, returns the controller to its reset state and selects the identification word.

Top module: `scan_tap`

## Requirements
- R1: While `scan_rst_n` is low, the controller is held in the reset state, `scan_out_en` is 0 and `pin_out` equals `core_out`. After reset the instruction is the identification opcode 5'b00001.
- R2: From any state, five consecutive rising edges with `mode_sel` high put the controller in the reset state, and the instruction becomes the identification opcode.
- R3: Capture-IR loads 5'b00001 into the instruction shift stage, so the first five bits shifted out of an instruction scan are 1,0,0,0,0.
- R4: With the identification opcode 5'b00001, a data scan shifts out ID_WORD (default 32'h0535217F), least-significant bit first.
- R5: With opcode 5'b11111, a data scan shifts out a captured 0 and then each input bit delayed by exactly one clock.
- R6: Every opcode other than 5'b00000, 5'b00001, 5'b00010 and 5'b11111 behaves as opcode 5'b11111.
- R7: With opcode 5'b00000, capture loads `pin_in` and `pin_out` equals the boundary update stage (bit 0 scanned first). Changes on `core_out` have no effect on `pin_out`.
- R8: With opcode 5'b00010, capture loads `pin_in` and Update-DR preloads the update stage while `pin_out` keeps following `core_out`. A later switch to 5'b00000 drives the preloaded value.
- R9: `scan_out_en` is 1 exactly while the controller is in Shift-IR or Shift-DR, and it changes on the falling edge.
- R10: Pulling `scan_rst_n` low in the middle of a scan clears `scan_out_en` at once. After release, the identification word can be read.
- R11: A data scan paused through Exit1, Pause and Exit2 resumes with no bit lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Test clock |
| scan_rst_n | input | 1 | Asynchronous active-low controller reset |
| mode_sel | input | 1 | Controller steering input, sampled on the rising edge |
| scan_in | input | 1 | Serial data input |
| scan_out | output | 1 | Serial data output, updated on the falling edge |
| scan_out_en | output | 1 | High while `scan_out` is valid (shift states) |
| pin_in | input | PIN_W | Pin levels seen by the boundary cells |
| core_out | input | PIN_W | Values the core wants on the pins |
| pin_out | output | PIN_W | Values driven to the pins |

## Verification
The assertions assume that `mode_sel` and `scan_in` only change away from the rising edge. They also assume that `scan_rst_n` is the only path that reaches the controller other than the clocked steering. The bench changes its inputs shortly after each falling edge and reads the outputs at that same point. This keeps every rising edge seeing settled values. Random walks of the steering line, random opcodes and random pin and data patterns are all produced inside that timing. Resets in the middle of a scan are applied between edges.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int          PIN_W   = 4,
  parameter logic [31:0] ID_WORD = 32'h0535217F
) (
  input  logic             scan_clk,
  input  logic             scan_rst_n,
  input  logic             mode_sel,
  input  logic             scan_in,
  output logic             scan_out,
  output logic             scan_out_en,
  input  logic [PIN_W-1:0] pin_in,
  input  logic [PIN_W-1:0] core_out,
  output logic [PIN_W-1:0] pin_out
);
  localparam int ID_W = 32;
  localparam int IR_W = 5;
  localparam logic [IR_W-1:0] OP_DRIVE = 5'b00000;
  localparam logic [IR_W-1:0] OP_IDENT = 5'b00001;
  localparam logic [IR_W-1:0] OP_SNAP  = 5'b00010;
  localparam logic [IR_W-1:0] IR_CAPT  = 5'b00001;

  typedef enum logic [3:0] {
    S_RESET = 4'd0,  S_IDLE = 4'd1,   S_SEL_DR = 4'd2,  S_CAP_DR = 4'd3,
    S_SHF_DR = 4'd4, S_EX1_DR = 4'd5, S_PAU_DR = 4'd6,  S_EX2_DR = 4'd7,
    S_UPD_DR = 4'd8, S_SEL_IR = 4'd9, S_CAP_IR = 4'd10, S_SHF_IR = 4'd11,
    S_EX1_IR = 4'd12, S_PAU_IR = 4'd13, S_EX2_IR = 4'd14, S_UPD_IR = 4'd15
  } tap_st_t;

  tap_st_t          state, nxt;
  logic [IR_W-1:0]  ir_sh, ir_q;
  logic [ID_W-1:0]  id_sh;
  logic [PIN_W-1:0] bsr_sh, bsr_upd;
  logic             byp, tdo_q, oe_q;

  wire sel_id  = (ir_q == OP_IDENT);
  wire sel_bsr = (ir_q == OP_DRIVE) || (ir_q == OP_SNAP);
  wire dr_lsb  = sel_id ? id_sh[0] : (sel_bsr ? bsr_sh[0] : byp);

  always_comb begin
    case (state)
      S_RESET:  nxt = mode_sel ? S_RESET  : S_IDLE;
      S_IDLE:   nxt = mode_sel ? S_SEL_DR : S_IDLE;
      S_SEL_DR: nxt = mode_sel ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = mode_sel ? S_EX1_DR : S_SHF_DR;
      S_SHF_DR: nxt = mode_sel ? S_EX1_DR : S_SHF_DR;
      S_EX1_DR: nxt = mode_sel ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = mode_sel ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = mode_sel ? S_UPD_DR : S_SHF_DR;
      S_UPD_DR: nxt = mode_sel ? S_SEL_DR : S_IDLE;
      S_SEL_IR: nxt = mode_sel ? S_RESET  : S_CAP_IR;
      S_CAP_IR: nxt = mode_sel ? S_EX1_IR : S_SHF_IR;
      S_SHF_IR: nxt = mode_sel ? S_EX1_IR : S_SHF_IR;
      S_EX1_IR: nxt = mode_sel ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = mode_sel ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = mode_sel ? S_UPD_IR : S_SHF_IR;
      default:  nxt = mode_sel ? S_SEL_DR : S_IDLE;
    endcase
  end

  always_ff @(posedge scan_clk or negedge scan_rst_n)
    if (!scan_rst_n) state <= S_RESET;
    else             state <= nxt;

  always_ff @(posedge scan_clk or negedge scan_rst_n)
    if (!scan_rst_n) begin
      ir_sh  <= '0;
      id_sh  <= '0;
      bsr_sh <= '0;
      byp    <= 1'b0;
    end else begin
      case (state)
        S_CAP_IR: ir_sh <= IR_CAPT;
        S_SHF_IR: ir_sh <= {scan_in, ir_sh[IR_W-1:1]};
        S_CAP_DR:
          if (sel_id)       id_sh  <= ID_WORD;
          else if (sel_bsr) bsr_sh <= pin_in;
          else              byp    <= 1'b0;
        S_SHF_DR:
          if (sel_id)       id_sh  <= {scan_in, id_sh[ID_W-1:1]};
          else if (sel_bsr) bsr_sh <= (bsr_sh >> 1) | (PIN_W'(scan_in) << (PIN_W-1));
          else              byp    <= scan_in;
        default: ;
      endcase
    end

  always_ff @(negedge scan_clk or negedge scan_rst_n)
    if (!scan_rst_n) begin
      ir_q    <= OP_IDENT;
      bsr_upd <= '0;
      tdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (state == S_RESET)       ir_q <= OP_IDENT;
      else if (state == S_UPD_IR) ir_q <= ir_sh;
      if (state == S_UPD_DR && sel_bsr) bsr_upd <= bsr_sh;
      oe_q  <= (state == S_SHF_IR) || (state == S_SHF_DR);
      tdo_q <= (state == S_SHF_IR) ? ir_sh[0] : dr_lsb;
    end

  assign scan_out    = tdo_q;
  assign scan_out_en = oe_q;
  assign pin_out     = (ir_q == OP_DRIVE) ? bsr_upd : core_out;
endmodule

module scan_tap_chk #(
  parameter int PIN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tms,
  input logic             oe,
  input logic [3:0]       st,
  input logic [4:0]       ir,
  input logic [4:0]       ir_sh,
  input logic [PIN_W-1:0] pin_out
);
  logic [2:0] ones;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   ones <= '0;
    else if (tms) ones <= (ones == 3'd7) ? ones : ones + 3'd1;
    else          ones <= '0;

  a_r2_five_ones_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (ones >= 3'd5) |-> (st == 4'd0));

  a_r1_reset_selects_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0) |-> (ir == 5'b00001));

  a_r3_capture_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 4'd10) |-> (ir_sh == 5'b00001));

  a_r9_enable_only_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (st == 4'd4 || st == 4'd11));

  a_r9_shift_has_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd4 || st == 4'd11) |-> oe);

  a_r7_drive_holds_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (ir == 5'b00000 && $past(ir) == 5'b00000 && st != 4'd8 && st != 4'd15)
      |-> $stable(pin_out));
endmodule

bind scan_tap scan_tap_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(scan_clk), .rst_n(scan_rst_n), .tms(mode_sel), .oe(scan_out_en),
  .st(state), .ir(ir_q), .ir_sh(ir_sh), .pin_out(pin_out)
);

// File: tb/tb_scan_tap.sv
module tb_scan_tap;
  localparam int TCK_P = 20;
  localparam int PIN_W = 4;
  localparam logic [31:0] ID_EXP = 32'h0535217F;

  logic clk = 1'b0;
  logic scan_rst_n = 1'b0;
  logic mode_sel = 1'b1;
  logic scan_in = 1'b0;
  logic scan_out, scan_out_en;
  logic [PIN_W-1:0] pin_in = '0, core_out = '0, pin_out;

  int vecs = 0;
  int miss = 0;
  logic oe_err = 1'b0;

  scan_tap #(.PIN_W(PIN_W)) dut (
    .scan_clk(clk), .scan_rst_n(scan_rst_n), .mode_sel(mode_sel), .scan_in(scan_in),
    .scan_out(scan_out), .scan_out_en(scan_out_en),
    .pin_in(pin_in), .core_out(core_out), .pin_out(pin_out)
  );

  always #(TCK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic t, input logic d, output logic o, output logic e);
    @(negedge clk);
    #2;
    o = scan_out;
    e = scan_out_en;
    mode_sel = t;
    scan_in = d;
    @(posedge clk);
  endtask

  task automatic nav(input logic t);
    logic o, e;
    step(t, 1'b0, o, e);
    if (e !== 1'b0) oe_err = 1'b1;
  endtask

  task automatic sbit(input logic t, input logic d, output logic o);
    logic e;
    step(t, d, o, e);
    if (e !== 1'b1) oe_err = 1'b1;
  endtask

  task automatic tap_reset();
    logic o, e;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e);
    nav(1'b0);
  endtask

  task automatic shift_ir(input logic [4:0] op, output logic [4:0] cap);
    logic o;
    nav(1'b1); nav(1'b1); nav(1'b0); nav(1'b0);
    for (int i = 0; i < 5; i++) begin
      sbit(i == 4, op[i], o);
      cap[i] = o;
    end
    nav(1'b1); nav(1'b0);
  endtask

  task automatic shift_dr(input int len, input logic [63:0] din, input int pause_at,
                          output logic [63:0] dout);
    logic o;
    dout = '0;
    nav(1'b1); nav(1'b0); nav(1'b0);
    for (int i = 0; i < len; i++) begin
      sbit((i == len-1) || (i == pause_at), din[i], o);
      dout[i] = o;
      if (i == pause_at && i != len-1) begin
        nav(1'b0); nav(1'b0); nav(1'b1); nav(1'b0);
      end
    end
    nav(1'b1); nav(1'b0);
  endtask

  function automatic logic [63:0] byp_exp(input logic [63:0] din, input int len);
    logic [63:0] r = '0;
    for (int i = 1; i < len; i++) r[i] = din[i-1];
    return r;
  endfunction

  function automatic bit is_known(input logic [4:0] op);
    return op == 5'b00000 || op == 5'b00001 || op == 5'b00010 || op == 5'b11111;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    #(TCK_P * 200000);
    miss++;
    $display("FAIL watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [4:0]  cap, op;
    logic [63:0] din, dout;
    logic [PIN_W-1:0] pre, pv, cv;
    logic o, e;
    void'($urandom(32'd4242));

    core_out = 4'b1010;
    pin_in   = 4'b0110;
    #(TCK_P * 3 + 3);
    chk("R1 enable in reset", {63'd0, scan_out_en}, 64'd0);
    chk("R1 pins follow core in reset", {60'd0, pin_out}, {60'd0, core_out});
    @(negedge clk); #2; scan_rst_n = 1'b1;
    nav(1'b0);
    shift_dr(32, '0, -1, dout);
    chk("R1 R4 ident after reset", dout, {32'd0, ID_EXP});
    chk("R9 enable low in idle", {63'd0, scan_out_en}, 64'd0);

    shift_ir(5'b11111, cap);
    chk("R3 instruction capture", {59'd0, cap}, 64'd1);
    for (int k = 0; k < 3; k++) begin
      din = {$urandom, $urandom};
      shift_dr(20, din, -1, dout);
      chk("R5 bypass delay", dout & 64'hFFFFF, byp_exp(din, 20));
    end

    for (int k = 0; k < 3; k++) begin
      do op = 5'($urandom); while (is_known(op));
      shift_ir(op, cap);
      chk("R3 capture under random opcode", {59'd0, cap}, 64'd1);
      din = {$urandom, $urandom};
      shift_dr(12, din, -1, dout);
      chk("R6 unassigned opcode acts as bypass", dout & 64'hFFF, byp_exp(din, 12));
    end

    shift_ir(5'b00010, cap);
    pv = PIN_W'($urandom); cv = PIN_W'($urandom); pre = PIN_W'($urandom);
    pin_in = pv; core_out = cv;
    shift_dr(PIN_W, {60'd0, pre}, -1, dout);
    chk("R8 snapshot captures pins", dout, {60'd0, pv});
    chk("R8 snapshot leaves pins to core", {60'd0, pin_out}, {60'd0, cv});
    shift_ir(5'b00000, cap);
    chk("R8 preload driven after switch", {60'd0, pin_out}, {60'd0, pre});
    core_out = ~cv;
    nav(1'b0); nav(1'b0);
    chk("R7 core ignored while driving", {60'd0, pin_out}, {60'd0, pre});
    for (int k = 0; k < 3; k++) begin
      pv = PIN_W'($urandom); din = {60'd0, PIN_W'($urandom)};
      pin_in = pv;
      shift_dr(PIN_W, din, -1, dout);
      chk("R7 drive captures pins", dout, {60'd0, pv});
      chk("R7 drive updates pins", {60'd0, pin_out}, din);
    end

    shift_ir(5'b00001, cap);
    shift_dr(32, '0, 10, dout);
    chk("R11 paused ident scan", dout, {32'd0, ID_EXP});
    shift_ir(5'b11111, cap);
    din = {$urandom, $urandom};
    shift_dr(16, din, 5, dout);
    chk("R11 paused bypass scan", dout & 64'hFFFF, byp_exp(din, 16));

    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 30; j++) step(1'($urandom), 1'($urandom), o, e);
      tap_reset();
      shift_dr(32, '0, -1, dout);
      chk("R2 five ones restore ident", dout, {32'd0, ID_EXP});
    end

    shift_ir(5'b11111, cap);
    nav(1'b1); nav(1'b0); nav(1'b0);
    sbit(1'b0, 1'b1, o); sbit(1'b0, 1'b0, o);
    @(negedge clk); #2;
    chk("R10 enable high mid scan", {63'd0, scan_out_en}, 64'd1);
    #3; scan_rst_n = 1'b0; #1;
    chk("R10 enable cleared by async reset", {63'd0, scan_out_en}, 64'd0);
    #(TCK_P); @(negedge clk); #2; scan_rst_n = 1'b1; mode_sel = 1'b1;
    nav(1'b0);
    shift_dr(32, '0, -1, dout);
    chk("R10 ident after mid-scan reset", dout, {32'd0, ID_EXP});

    chk("R9 enable matched shift states", {63'd0, oe_err}, 64'd0);
    finish_run();
  end
endmodule